// File: doc/BRIEF.md
# Single-Cycle 32-bit Integer Core

This block is a 32-bit processor core that retires one instruction on every rising clock edge. During a single cycle it presents the program counter on the instruction port and splits the returned word into fixed fields. It reads two operands from a 32-entry register file and computes a result in the ALU. It then presents an address to the data port and, at the closing clock edge, updates the register file, the data memory (through the write enable) and the program counter together.

Both memories sit outside the core and answer combinationally: the instruction word and the load data must be valid in the same cycle that the address appears. The core handles five instruction kinds: register-register arithmetic and logic, word load, word store, branch on equal, and an absolute jump within the current 256 MB region.

Top module: `sc_core`

## Requirements
- R1: A synchronous active-high `rst` forces the program counter to 0 at the next rising edge, and `imem_addr` shows 0 while reset is held.
- R2: An instruction that is neither a taken branch nor a jump moves the program counter to PC+4.
- R3: Opcode 0x00 writes register bits 15-11 with the result selected by function bits 5-0: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR, 0x2A signed set-less-than (1 or 0).
- R4: Opcode 0x23 (load) drives `dmem_rd_en`=1 and `dmem_addr` = register[25-21] + sign-extended bits 15-0, and writes `dmem_rdata` into register bits 20-16.
- R5: Opcode 0x2B (store) drives `dmem_wr_en`=1, the same address as a load, and `dmem_wdata` = register[20-16]. It does not write the register file.
- R6: Opcode 0x04 compares register[25-21] with register[20-16]. When they are equal the next PC is PC+4 + (sign-extended bits 15-0 shifted left by 2), in either direction. Otherwise the next PC is PC+4. The instruction writes neither registers nor memory.
- R7: Opcode 0x02 sets the next PC to {PC+4 bits 31-28, instruction bits 25-0, 2'b00} and writes neither registers nor memory.
- R8: Register 0 always reads as zero, and writes addressed to it are discarded.
- R9: `dmem_rd_en` and `dmem_wr_en` are never high together. Each is high only for its own opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | 32 | Byte address of the current instruction (the PC) |
| imem_rdata | input | 32 | Instruction word, valid in the same cycle |
| dmem_addr | output | 32 | Byte address for load or store |
| dmem_wdata | output | 32 | Store data |
| dmem_rd_en | output | 1 | Load in progress this cycle |
| dmem_wr_en | output | 1 | Store in progress; memory captures at the rising edge |
| dmem_rdata | input | 32 | Load data, valid in the same cycle |

## Verification
The data-port outputs are combinational, so they are due in the same cycle as the instruction word that causes them. The new program counter, register contents and stored memory words appear only after the next rising edge. The bench changes stimulus and samples outputs on the falling edge. It compares one expected row per cycle: the PC that row must show, together with that cycle's memory request. Register results are therefore observed one or more cycles later through the stores that expose them. Skipped instructions are proven absent by sentinel words left untouched in memory.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int XLEN    = 32;
  localparam int RIDX_W  = 5;
  localparam int NREGS   = 2 ** RIDX_W;
  localparam int IMM_W   = 16;
  localparam int JIDX_W  = 26;
  localparam int REGION_W = XLEN - JIDX_W - 2;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_JMP   = 6'h02;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [1:0] {
    AOP_ADD   = 2'b00,
    AOP_SUB   = 2'b01,
    AOP_FUNCT = 2'b10,
    AOP_RSVD  = 2'b11
  } aluop_e;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT
  } alu_fn_e;

  typedef struct packed {
    logic   reg_dst;
    aluop_e alu_op;
    logic   alu_src;
    logic   branch;
    logic   mem_read;
    logic   mem_write;
    logic   reg_write;
    logic   mem_to_reg;
    logic   jump;
  } ctrl_t;

  function automatic logic [XLEN-1:0] sext_imm(input logic [IMM_W-1:0] imm);
    return {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
  endfunction

  function automatic logic [XLEN-1:0] branch_target(input logic [XLEN-1:0] seq_pc,
                                                    input logic [XLEN-1:0] imm_ext);
    return seq_pc + {imm_ext[XLEN-3:0], 2'b00};
  endfunction

  function automatic logic [XLEN-1:0] jump_target(input logic [XLEN-1:0] seq_pc,
                                                  input logic [JIDX_W-1:0] idx);
    return {seq_pc[XLEN-1 -: REGION_W], idx, 2'b00};
  endfunction

  function automatic alu_fn_e alu_select(input aluop_e op, input logic [5:0] fn);
    alu_fn_e sel;
    sel = ALU_ADD;
    case (op)
      AOP_SUB: sel = ALU_SUB;
      AOP_FUNCT: begin
        case (fn)
          FN_SUB:  sel = ALU_SUB;
          FN_AND:  sel = ALU_AND;
          FN_OR:   sel = ALU_OR;
          FN_SLT:  sel = ALU_SLT;
          default: sel = ALU_ADD;
        endcase
      end
      default: sel = ALU_ADD;
    endcase
    return sel;
  endfunction
endpackage

// File: rtl/sc_ctrl.sv
module sc_ctrl
  import sc_pkg::*;
(
  input  logic [5:0] opcode,
  output ctrl_t      ctrl
);
  always_comb begin
    ctrl = '0;
    case (opcode)
      OP_RTYPE: begin
        ctrl.reg_dst   = 1'b1;
        ctrl.alu_op    = AOP_FUNCT;
        ctrl.reg_write = 1'b1;
      end
      OP_LW: begin
        ctrl.alu_op     = AOP_ADD;
        ctrl.alu_src    = 1'b1;
        ctrl.mem_read   = 1'b1;
        ctrl.reg_write  = 1'b1;
        ctrl.mem_to_reg = 1'b1;
      end
      OP_SW: begin
        ctrl.reg_dst    = 1'bx;
        ctrl.mem_to_reg = 1'bx;
        ctrl.alu_op     = AOP_ADD;
        ctrl.alu_src    = 1'b1;
        ctrl.mem_write  = 1'b1;
      end
      OP_BEQ: begin
        ctrl.reg_dst    = 1'bx;
        ctrl.mem_to_reg = 1'bx;
        ctrl.alu_op     = AOP_SUB;
        ctrl.branch     = 1'b1;
      end
      OP_JMP: begin
        ctrl.jump = 1'b1;
      end
      default: ctrl = '0;
    endcase
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
(
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  aluop_e          op,
  input  logic [5:0]      funct,
  output logic [XLEN-1:0] y,
  output logic            zero
);
  alu_fn_e fn_sel;

  assign fn_sel = alu_select(op, funct);

  always_comb begin
    case (fn_sel)
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SLT: y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = a + b;
    endcase
  end

  assign zero = (y == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int W = 32,
  parameter int N = 32,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [W-1:0]  rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_b
);
  logic [W-1:0] bank [N];

  always_ff @(posedge clk) begin
    if (we && (waddr != '0)) bank[waddr] <= wdata;
  end

  assign rdata_a = (raddr_a == '0) ? '0 : bank[raddr_a];
  assign rdata_b = (raddr_b == '0) ? '0 : bank[raddr_b];
endmodule

// File: rtl/sc_pcunit.sv
module sc_pcunit
  import sc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              take_branch,
  input  logic              do_jump,
  input  logic [XLEN-1:0]   imm_ext,
  input  logic [JIDX_W-1:0] jidx,
  output logic [XLEN-1:0]   pc_q,
  output logic [XLEN-1:0]   pc_plus4
);
  logic [XLEN-1:0] pc_next;

  assign pc_plus4 = pc_q + XLEN'(4);

  always_comb begin
    if (do_jump)          pc_next = jump_target(pc_plus4, jidx);
    else if (take_branch) pc_next = branch_target(pc_plus4, imm_ext);
    else                  pc_next = pc_plus4;
  end

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_next;
  end
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  output logic [31:0] imem_addr,
  input  logic [31:0] imem_rdata,
  output logic [31:0] dmem_addr,
  output logic [31:0] dmem_wdata,
  output logic        dmem_rd_en,
  output logic        dmem_wr_en,
  input  logic [31:0] dmem_rdata
);
  logic [XLEN-1:0]   instr;
  logic [5:0]        opcode;
  logic [RIDX_W-1:0] rs_idx, rt_idx, rd_idx, wr_idx;
  logic [5:0]        funct;
  logic [IMM_W-1:0]  imm;
  logic [JIDX_W-1:0] jidx;
  logic [XLEN-1:0]   imm_ext, rs_val, rt_val, alu_b, alu_res, wb_val;
  logic [XLEN-1:0]   pc_q, pc_plus4;
  logic              alu_zero, take_branch, do_jump, reg_we;
  ctrl_t             ctrl;

  assign instr  = imem_rdata;
  assign opcode = instr[31:26];
  assign rs_idx = instr[25:21];
  assign rt_idx = instr[20:16];
  assign rd_idx = instr[15:11];
  assign funct  = instr[5:0];
  assign imm    = instr[15:0];
  assign jidx   = instr[25:0];

  sc_ctrl u_ctrl (
    .opcode (opcode),
    .ctrl   (ctrl)
  );

  assign imm_ext = sext_imm(imm);
  assign wr_idx  = ctrl.reg_dst ? rd_idx : rt_idx;
  assign reg_we  = ctrl.reg_write;
  assign wb_val  = ctrl.mem_to_reg ? dmem_rdata : alu_res;

  sc_regfile #(.W(XLEN), .N(NREGS)) u_rf (
    .clk     (clk),
    .we      (reg_we),
    .waddr   (wr_idx),
    .wdata   (wb_val),
    .raddr_a (rs_idx),
    .rdata_a (rs_val),
    .raddr_b (rt_idx),
    .rdata_b (rt_val)
  );

  assign alu_b = ctrl.alu_src ? imm_ext : rt_val;

  sc_alu u_alu (
    .a     (rs_val),
    .b     (alu_b),
    .op    (ctrl.alu_op),
    .funct (funct),
    .y     (alu_res),
    .zero  (alu_zero)
  );

  assign take_branch = ctrl.branch & alu_zero;
  assign do_jump     = ctrl.jump;

  sc_pcunit u_pc (
    .clk         (clk),
    .rst         (rst),
    .take_branch (take_branch),
    .do_jump     (do_jump),
    .imm_ext     (imm_ext),
    .jidx        (jidx),
    .pc_q        (pc_q),
    .pc_plus4    (pc_plus4)
  );

  assign imem_addr  = pc_q;
  assign dmem_addr  = alu_res;
  assign dmem_wdata = rt_val;
  assign dmem_rd_en = ctrl.mem_read;
  assign dmem_wr_en = ctrl.mem_write;
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] pc,
  input logic [31:0] pc_plus4,
  input logic [31:0] instr,
  input logic        take_branch,
  input logic        do_jump,
  input logic        reg_we,
  input logic [4:0]  rs_idx,
  input logic [31:0] rs_val,
  input logic [31:0] rt_val,
  input logic        rd_en,
  input logic        wr_en
);
  logic rst_seen = 1'b0;

  always_ff @(posedge clk) rst_seen <= rst;

  // R1: one edge after reset the PC is zero
  always @(negedge clk) begin
    if (rst_seen) a_r1_reset_pc: assert (pc == 32'd0);
  end

  a_r2_seq_step: assert property (@(posedge clk) disable iff (rst)
    (!take_branch && !do_jump) |=> (pc == $past(pc) + 32'd4));

  a_r6_taken_equal: assert property (@(posedge clk) disable iff (rst)
    take_branch |-> (rs_val == rt_val));

  a_r6_taken_target: assert property (@(posedge clk) disable iff (rst)
    take_branch |=> (pc == $past(pc_plus4) + $past({{14{instr[15]}}, instr[15:0], 2'b00})));

  a_r7_jump_target: assert property (@(posedge clk) disable iff (rst)
    do_jump |=> (pc == $past({pc_plus4[31:28], instr[25:0], 2'b00})));

  a_r7_jump_no_write: assert property (@(posedge clk) disable iff (rst)
    do_jump |-> (!reg_we && !wr_en));

  a_r5_store_no_regwrite: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !reg_we);

  a_r8_zero_read: assert property (@(posedge clk) disable iff (rst)
    (rs_idx == 5'd0) |-> (rs_val == 32'd0));

  a_r9_rd_wr_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && wr_en));
endmodule

bind sc_core sc_core_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .pc          (pc_q),
  .pc_plus4    (pc_plus4),
  .instr       (instr),
  .take_branch (take_branch),
  .do_jump     (do_jump),
  .reg_we      (reg_we),
  .rs_idx      (rs_idx),
  .rs_val      (rs_val),
  .rt_val      (rt_val),
  .rd_en       (dmem_rd_en),
  .wr_en       (dmem_wr_en)
);

// File: tb/sc_core_tb.sv
module sc_core_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_rd_en, dmem_wr_en;

  logic [31:0] imem [64];
  logic [31:0] dmem [64];

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  localparam logic [31:0] SENT = 32'hDEAD_BEEF;

  always #10 clk = ~clk;

  assign imem_rdata = imem[imem_addr[7:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];

  always @(posedge clk) begin
    if (dmem_wr_en) dmem[dmem_addr[7:2]] <= dmem_wdata;
  end

  sc_core u_dut (
    .clk        (clk),
    .rst        (rst),
    .imem_addr  (imem_addr),
    .imem_rdata (imem_rdata),
    .dmem_addr  (dmem_addr),
    .dmem_wdata (dmem_wdata),
    .dmem_rd_en (dmem_rd_en),
    .dmem_wr_en (dmem_wr_en),
    .dmem_rdata (dmem_rdata)
  );

  typedef struct packed {
    logic [31:0] pc;
    logic [3:0]  req;
    logic        rd;
    logic        wr;
    logic [31:0] addr;
    logic [31:0] wdata;
  } vec_t;

  localparam int NVEC = 26;
  localparam vec_t VEC [NVEC] = '{
    '{32'h00, 4'd4, 1'b1, 1'b0, 32'h00, 32'h0},
    '{32'h04, 4'd4, 1'b1, 1'b0, 32'h04, 32'h0},
    '{32'h08, 4'd3, 1'b0, 1'b0, 32'h00, 32'h0},
    '{32'h0C, 4'd5, 1'b0, 1'b1, 32'h10, 32'h4},
    '{32'h10, 4'd3, 1'b0, 1'b0, 32'h00, 32'h0},
    '{32'h14, 4'd5, 1'b0, 1'b1, 32'h14, 32'hA},
    '{32'h18, 4'd3, 1'b0, 1'b0, 32'h00, 32'h0},
    '{32'h1C, 4'd5, 1'b0, 1'b1, 32'h18, 32'h5},
    '{32'h20, 4'd3, 1'b0, 1'b0, 32'h00, 32'h0},
    '{32'h24, 4'd5, 1'b0, 1'b1, 32'h1C, 32'hFFFF_FFFF},
    '{32'h28, 4'd3, 1'b0, 1'b0, 32'h00, 32'h0},
    '{32'h2C, 4'd5, 1'b0, 1'b1, 32'h20, 32'h1},
    '{32'h30, 4'd3, 1'b0, 1'b0, 32'h00, 32'h0},
    '{32'h34, 4'd5, 1'b0, 1'b1, 32'h24, 32'h0},
    '{32'h38, 4'd8, 1'b0, 1'b0, 32'h00, 32'h0},
    '{32'h3C, 4'd8, 1'b0, 1'b1, 32'h28, 32'h0},
    '{32'h40, 4'd6, 1'b0, 1'b0, 32'h00, 32'h0},
    '{32'h44, 4'd6, 1'b0, 1'b0, 32'h00, 32'h0},
    '{32'h50, 4'd6, 1'b0, 1'b1, 32'h00, 32'h7},
    '{32'h54, 4'd7, 1'b0, 1'b0, 32'h00, 32'h0},
    '{32'h60, 4'd7, 1'b0, 1'b0, 32'h00, 32'h0},
    '{32'h6C, 4'd6, 1'b0, 1'b0, 32'h00, 32'h0},
    '{32'h64, 4'd6, 1'b0, 1'b1, 32'h38, 32'hFFFF_FFFD},
    '{32'h68, 4'd7, 1'b0, 1'b0, 32'h00, 32'h0},
    '{32'h74, 4'd7, 1'b0, 1'b0, 32'h00, 32'h0},
    '{32'h74, 4'd7, 1'b0, 1'b0, 32'h00, 32'h0}
  };

  function automatic string req_name(input logic [3:0] n);
    case (n)
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      4'd8: return "R8";
      default: return "R2";
    endcase
  endfunction

  function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd,
                                        input logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'h00, fn};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt,
                                        input logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  function automatic logic [31:0] enc_j(input logic [25:0] idx);
    return {6'h02, idx};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      imem[i] = enc_j(26'h1D);
      dmem[i] = SENT;
    end
    dmem[0] = 32'd7;
    dmem[1] = 32'hFFFF_FFFD;
    imem[0]  = enc_i(6'h23, 0, 1, 16'd0);      // lw r1,0(r0)
    imem[1]  = enc_i(6'h23, 0, 2, 16'd4);      // lw r2,4(r0)
    imem[2]  = enc_r(1, 2, 3, 6'h20);          // add
    imem[3]  = enc_i(6'h2B, 0, 3, 16'd16);
    imem[4]  = enc_r(1, 2, 4, 6'h22);          // sub
    imem[5]  = enc_i(6'h2B, 0, 4, 16'd20);
    imem[6]  = enc_r(1, 2, 5, 6'h24);          // and
    imem[7]  = enc_i(6'h2B, 0, 5, 16'd24);
    imem[8]  = enc_r(1, 2, 6, 6'h25);          // or
    imem[9]  = enc_i(6'h2B, 0, 6, 16'd28);
    imem[10] = enc_r(2, 1, 7, 6'h2A);          // slt true
    imem[11] = enc_i(6'h2B, 0, 7, 16'd32);
    imem[12] = enc_r(1, 2, 8, 6'h2A);          // slt false
    imem[13] = enc_i(6'h2B, 0, 8, 16'd36);
    imem[14] = enc_r(1, 1, 0, 6'h20);          // write to r0
    imem[15] = enc_i(6'h2B, 0, 0, 16'd40);
    imem[16] = enc_i(6'h04, 1, 2, 16'd5);      // beq not taken
    imem[17] = enc_i(6'h04, 3, 3, 16'd2);      // beq taken forward
    imem[18] = enc_i(6'h2B, 0, 1, 16'd44);     // skipped
    imem[19] = enc_i(6'h2B, 0, 1, 16'd44);     // skipped
    imem[20] = enc_i(6'h2B, 3, 1, 16'hFFFC);   // negative offset store
    imem[21] = enc_j(26'h18);
    imem[22] = enc_i(6'h2B, 0, 1, 16'd48);     // skipped by jump
    imem[23] = enc_i(6'h2B, 0, 1, 16'd48);     // skipped by jump
    imem[24] = enc_i(6'h04, 0, 0, 16'd2);
    imem[25] = enc_i(6'h2B, 0, 2, 16'd56);     // reached by backward branch
    imem[26] = enc_j(26'h1D);
    imem[27] = enc_i(6'h04, 0, 0, 16'hFFFD);   // backward branch
    imem[28] = enc_i(6'h2B, 0, 1, 16'd48);     // skipped
    imem[29] = enc_j(26'h1D);

    repeat (2) @(posedge clk);
    @(negedge clk);
    #1;
    check("R1 pc in reset", imem_addr, 32'h0);
    rst = 1'b0;
    #1;

    for (int i = 0; i < NVEC; i++) begin
      check({req_name(VEC[i].req), " pc"}, imem_addr, VEC[i].pc);
      check("R9 rd_en", {31'd0, dmem_rd_en}, {31'd0, VEC[i].rd});
      check("R9 wr_en", {31'd0, dmem_wr_en}, {31'd0, VEC[i].wr});
      if (VEC[i].rd || VEC[i].wr)
        check({req_name(VEC[i].req), " addr"}, dmem_addr, VEC[i].addr);
      if (VEC[i].wr)
        check({req_name(VEC[i].req), " wdata"}, dmem_wdata, VEC[i].wdata);
      @(posedge clk);
      @(negedge clk);
      #1;
    end

    check("R5 negative offset store", dmem[0], 32'd7);
    check("R8 r0 stays zero", dmem[10], 32'd0);
    check("R6 skipped by branch", dmem[11], SENT);
    check("R7 skipped by jump", dmem[12], SENT);
    check("R6 backward target store", dmem[14], 32'hFFFF_FFFD);

    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    #1;
    check("R1 pc after mid-run reset", imem_addr, 32'h0);
    check("R1 load seen at pc 0", {31'd0, dmem_rd_en}, 32'd1);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    #1;
    check("R2 step after reset", imem_addr, 32'h4);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R2 actual=%h expected=%h", imem_addr, 32'h74);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule